// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block gives a processor core's debug logic a bank of `NUM_CMP` instruction-address comparators. Each comparator has an arm bit in a shared arm register and a 32-bit target address register. Software loads both through a simple write port. A write strobe plus an index selects a target register, and a separate strobe loads the arm register.

In every cycle that the core presents a valid program counter, each armed comparator checks its target against that counter for exact equality. When at least one armed comparator matches, the block raises a break request. It does this only while the core's current interrupt level is strictly below the configured debug level.

The match path is purely combinational from the program counter and level inputs to the outputs. This lets the core turn the request into a debug exception before the instruction at the matching address commits. A per-comparator hit vector is also driven so that the debug-cause logic can record which comparators fired.

Top module: `ibrk_unit`

## Requirements
- R1: After reset the arm register reads back as zero and every target register holds zero, so no comparator hits even when the program counter is zero.
- R2: A write to the arm register keeps only bits [NUM_CMP-1:0] of the data; `armRd` bits from NUM_CMP to 31 always read as zero.
- R3: `hitVec[i]` is high in a cycle exactly when `pcValid` is high, arm bit i is set, target register i equals `pc` on all 32 bits, and the level gate of R5 is open.
- R4: `breakReq` is high exactly when at least one bit of `hitVec` is high.
- R5: When `curIntLevel` is greater than or equal to `debugLevel`, `hitVec` is all zero and `breakReq` is low, regardless of any match.
- R6: A target write with `tgtWrIdx` = i < NUM_CMP replaces target register i at the clock edge, and the new address is the one compared from the following cycle on. The old address stops matching from that cycle.
- R7: Clearing an arm bit stops that comparator from hitting from the cycle after the write edge. Setting an arm bit makes the comparator match the address that target register i holds at that time.
- R8: A target write with `tgtWrIdx` >= NUM_CMP changes no target register.
- R9: While `pcValid` is low, `hitVec` is zero and `breakReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tgtWrStb | input | 1 | Write strobe for the target register picked by `tgtWrIdx` |
| tgtWrIdx | input | IDX_W | Target register index (IDX_W = clog2(NUM_CMP)+1) |
| armWrStb | input | 1 | Write strobe for the arm register |
| wrData | input | 32 | Write data shared by both strobes |
| pcValid | input | 1 | Program counter qualifier |
| pc | input | 32 | Program counter of the instruction being fetched or executed |
| curIntLevel | input | LVL_W | Current interrupt level of the core |
| debugLevel | input | LVL_W | Configured debug interrupt level |
| armRd | output | 32 | Arm register contents, zero-extended |
| hitVec | output | NUM_CMP | Per-comparator hit |
| breakReq | output | 1 | Debug break request |

## Verification
The assertions assume that reset is held for at least one clock edge, that the strobes and the write data are stable and known around each rising edge, and that `tgtWrIdx` may take any value, including values of NUM_CMP and above. The bench drives every input at the falling edge from initial-block tasks and keeps all values two-state. Its random phase picks indices from the full IDX_W range, so out-of-range writes occur. It draws program counters and target addresses from a small shared pool so that matches, multiple hits and level-gated matches all occur often.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

  localparam int unsigned WORD_W = 32;

  // Strobes passed from the control decoder to the comparator datapath.
  typedef struct packed {
    logic armWrite;   // load arm register from write data
    logic tgtWrite;   // a valid target write is in progress
    logic matchOpen;  // PC valid and interrupt level below debug level
  } ctrlStrobes_t;

endpackage

// File: rtl/ibrk_ctrl.sv
module ibrk_ctrl
  import ibrk_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  parameter int unsigned LVL_W   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tgtWrStb,
  input  logic [IDX_W-1:0]   tgtWrIdx,
  input  logic               armWrStb,
  input  logic               pcValid,
  input  logic [LVL_W-1:0]   curIntLevel,
  input  logic [LVL_W-1:0]   debugLevel,
  output ctrlStrobes_t       strb,
  output logic [NUM_CMP-1:0] tgtSel
);

  logic idxInRange;
  logic levelBelow;

  assign idxInRange = tgtWrIdx < IDX_W'(NUM_CMP);
  assign levelBelow = curIntLevel < debugLevel;

  always_comb begin
    strb           = '0;
    strb.armWrite  = armWrStb;
    strb.tgtWrite  = tgtWrStb && idxInRange;
    strb.matchOpen = pcValid && levelBelow;
  end

  // One-hot decode of the target index.
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_sel
    assign tgtSel[gi] = strb.tgtWrite && (tgtWrIdx == IDX_W'(gi));
  end

  // R8
  out_of_range_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtWrStb && (tgtWrIdx >= IDX_W'(NUM_CMP))) |-> (tgtSel == '0));

  // R6
  single_target_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel));

  // R5
  level_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curIntLevel >= debugLevel) |-> !strb.matchOpen);

  // R9
  pc_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pcValid |-> !strb.matchOpen);

endmodule

// File: rtl/ibrk_datapath.sv
module ibrk_datapath
  import ibrk_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [NUM_CMP-1:0] tgtSel,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [WORD_W-1:0]  pc,
  output logic [WORD_W-1:0]  armRd,
  output logic [NUM_CMP-1:0] hitVec
);

  logic [NUM_CMP-1:0] armReg;
  logic [WORD_W-1:0]  tgtReg [NUM_CMP];

  // Arm register: only the bits of existing comparators are stored.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armReg <= '0;
    end else if (strb.armWrite) begin
      armReg <= wrData[NUM_CMP-1:0];
    end
  end

  always_comb begin
    armRd              = '0;
    armRd[NUM_CMP-1:0] = armReg;
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    logic addrEq;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tgtReg[gi] <= '0;
      end else if (tgtSel[gi]) begin
        tgtReg[gi] <= wrData;
      end
    end

    assign addrEq     = (tgtReg[gi] == pc);
    assign hitVec[gi] = strb.matchOpen && armReg[gi] && addrEq;

    // R6
    tgt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      tgtSel[gi] |=> (tgtReg[gi] == $past(wrData)));

    // R8
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !tgtSel[gi] |=> $stable(tgtReg[gi]));

    // R3
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[gi] |-> (armReg[gi] && (tgtReg[gi] == pc) && strb.matchOpen));
  end

  // R7
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.armWrite |=> $stable(armReg));

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  parameter int unsigned LVL_W   = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_CMP) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tgtWrStb,
  input  logic [IDX_W-1:0]   tgtWrIdx,
  input  logic               armWrStb,
  input  logic [31:0]        wrData,
  input  logic               pcValid,
  input  logic [31:0]        pc,
  input  logic [LVL_W-1:0]   curIntLevel,
  input  logic [LVL_W-1:0]   debugLevel,
  output logic [31:0]        armRd,
  output logic [NUM_CMP-1:0] hitVec,
  output logic               breakReq
);

  ctrlStrobes_t       strb;
  logic [NUM_CMP-1:0] tgtSel;

  ibrk_ctrl #(.NUM_CMP(NUM_CMP), .LVL_W(LVL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tgtWrStb    (tgtWrStb),
    .tgtWrIdx    (tgtWrIdx),
    .armWrStb    (armWrStb),
    .pcValid     (pcValid),
    .curIntLevel (curIntLevel),
    .debugLevel  (debugLevel),
    .strb        (strb),
    .tgtSel      (tgtSel)
  );

  ibrk_datapath #(.NUM_CMP(NUM_CMP)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .tgtSel (tgtSel),
    .wrData (wrData),
    .pc     (pc),
    .armRd  (armRd),
    .hitVec (hitVec)
  );

  assign breakReq = |hitVec;

  // R5
  no_break_high_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curIntLevel >= debugLevel) |-> !breakReq);

  // R9
  no_break_invalid_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pcValid |-> (hitVec == '0));

  // R2
  arm_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    armRd[31:NUM_CMP] == '0);

endmodule

// File: tb/sim_ibrk_unit.sv
`timescale 1ns/1ps
module sim_ibrk_unit;

  localparam int unsigned N     = 4;
  localparam int unsigned LVL_W = 4;
  localparam int unsigned IDX_W = $clog2(N) + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tgtWrStb = 1'b0;
  logic [IDX_W-1:0] tgtWrIdx = '0;
  logic             armWrStb = 1'b0;
  logic [31:0]      wrData = '0;
  logic             pcValid = 1'b0;
  logic [31:0]      pc = '0;
  logic [LVL_W-1:0] curIntLevel = '0;
  logic [LVL_W-1:0] debugLevel = '0;
  logic [31:0]      armRd;
  logic [N-1:0]     hitVec;
  logic             breakReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] expArm;
  logic [31:0]  expTgt [N];
  logic [31:0]  pool [8];

  always #2 clk = ~clk;

  ibrk_unit #(.NUM_CMP(N), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rstN(rstN), .tgtWrStb(tgtWrStb), .tgtWrIdx(tgtWrIdx),
    .armWrStb(armWrStb), .wrData(wrData), .pcValid(pcValid), .pc(pc),
    .curIntLevel(curIntLevel), .debugLevel(debugLevel),
    .armRd(armRd), .hitVec(hitVec), .breakReq(breakReq)
  );

  function automatic logic [N-1:0] calcHits(logic pv, logic [31:0] p,
                                            logic [LVL_W-1:0] lv,
                                            logic [LVL_W-1:0] dl);
    logic [N-1:0] h = '0;
    for (int i = 0; i < N; i++)
      h[i] = pv && (lv < dl) && expArm[i] && (expTgt[i] == p);
    return h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle: inputs at the falling edge, compare combinational
  // outputs against the model, then apply the writes to the model at the
  // rising edge.
  task automatic step(logic tw, logic [IDX_W-1:0] ti, logic aw,
                      logic [31:0] d, logic pv, logic [31:0] p,
                      logic [LVL_W-1:0] lv, logic [LVL_W-1:0] dl, string req);
    logic [N-1:0] eh;
    @(negedge clk);
    tgtWrStb = tw; tgtWrIdx = ti; armWrStb = aw; wrData = d;
    pcValid = pv; pc = p; curIntLevel = lv; debugLevel = dl;
    #0.5;
    eh = calcHits(pv, p, lv, dl);
    chk({req, " hitVec"}, 32'(hitVec), 32'(eh));
    chk("R4 breakReq", 32'(breakReq), 32'(|eh));
    chk("R2 armRd", armRd, 32'(expArm));
    @(posedge clk);
    if (aw) expArm = d[N-1:0];
    if (tw && ti < IDX_W'(N)) expTgt[ti] = d;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, '0, "idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedv;
    expArm = '0;
    for (int i = 0; i < N; i++) expTgt[i] = '0;
    for (int i = 0; i < 8; i++) pool[i] = 32'h4000_0000 + 32'(i) * 32'h14;
    seedv = $urandom(32'd2024);

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state, PC zero with the gate open
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h0, 4'd0, 4'd3, "R1");
    chk("R1 armRd", armRd, 32'h0);

    // R2: all-ones arm write keeps only existing comparators
    step(1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0, '0, "R2");
    idle();
    chk("R2 armRd upper", armRd, 32'h0000_000F);
    // all targets still zero: PC 0 hits everything
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h0, 4'd1, 4'd2, "R3");
    chk("R3 all hit", 32'(hitVec), 32'hF);

    // R6: load target 2, old value stops matching the next cycle
    step(1'b1, 3'd2, 1'b0, 32'h1234_5678, 1'b1, 32'h0, 4'd0, 4'd2, "R6");
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h1234_5678, 4'd0, 4'd2, "R6");
    chk("R6 new target", 32'(hitVec), 32'h4);
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h0, 4'd0, 4'd2, "R6");
    chk("R6 old target", 32'(hitVec), 32'hB);

    // R3: one bit off never matches
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h1234_5679, 4'd0, 4'd2, "R3");
    chk("R3 near miss", 32'(breakReq), 32'h0);

    // R5: equal and higher level block a match
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h1234_5678, 4'd2, 4'd2, "R5");
    chk("R5 equal level", 32'(breakReq), 32'h0);
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h1234_5678, 4'd9, 4'd2, "R5");

    // R9: invalid PC
    step(1'b0, '0, 1'b0, '0, 1'b0, 32'h1234_5678, 4'd0, 4'd2, "R9");
    chk("R9 pc invalid", 32'(hitVec), 32'h0);

    // R7: disarm comparator 2, it stops after the edge
    step(1'b0, '0, 1'b1, 32'h0000_000B, 1'b1, 32'h1234_5678, 4'd0, 4'd2, "R7");
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h1234_5678, 4'd0, 4'd2, "R7");
    chk("R7 disarmed", 32'(hitVec), 32'h0);
    // re-arm picks up the address held meanwhile
    step(1'b1, 3'd2, 1'b0, 32'hCAFE_0010, 1'b0, '0, '0, '0, "R7");
    step(1'b0, '0, 1'b1, 32'h0000_0004, 1'b0, '0, '0, '0, "R7");
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'hCAFE_0010, 4'd0, 4'd1, "R7");
    chk("R7 rearmed", 32'(hitVec), 32'h4);

    // R8: out-of-range index writes nothing
    step(1'b1, 3'd4, 1'b0, 32'h0BAD_0000, 1'b0, '0, '0, '0, "R8");
    step(1'b1, 3'd7, 1'b0, 32'h0BAD_0000, 1'b0, '0, '0, '0, "R8");
    step(1'b0, '0, 1'b1, 32'h0000_000F, 1'b0, '0, '0, '0, "R8");
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'h0BAD_0000, 4'd0, 4'd1, "R8");
    chk("R8 no hit", 32'(hitVec), 32'h0);
    step(1'b0, '0, 1'b0, '0, 1'b1, 32'hCAFE_0010, 4'd0, 4'd1, "R8");
    chk("R8 target 2 kept", 32'(hitVec), 32'h4);

    // Random phase (R3 R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 2000; k++) begin
      logic             tw, aw, pv;
      logic [IDX_W-1:0] ti;
      logic [31:0]      d, p;
      logic [LVL_W-1:0] lv, dl;
      tw = ($urandom % 3) == 0;
      aw = ($urandom % 5) == 0;
      ti = IDX_W'($urandom);
      d  = aw ? $urandom : pool[$urandom % 8];
      pv = ($urandom % 6) != 0;
      p  = pool[$urandom % 8];
      lv = LVL_W'($urandom % 6);
      dl = LVL_W'($urandom % 6);
      step(tw, ti, aw, d, pv, p, lv, dl, "R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule